// File: doc/BRIEF.md
# Rotating-Priority Interrupt Resolver

This core arbitrates eight interrupt request lines for a single processor. Each line is latched into a pending register. Two rules set how a line is latched. A level-sensitive line follows its input. An edge-sensitive line latches only on a rising transition. Lines held off by the mask register do not compete. Priority is not fixed: it is measured from a rotation offset, so the input at the offset ranks highest and the ranking wraps modulo eight. The core raises its request output only when the best unmasked pending input outranks everything already in service.

The surrounding logic sends single-cycle pulses: acknowledge, end-of-interrupt (plain or rotating) and a rotate command. Mask and trigger-mode registers are written through load strobes. Operating modes and the vector base are static inputs:

- automatic end-of-interrupt
- rotation on automatic end-of-interrupt
- nested handling of the cascade line on a master

On acknowledge, the core reports the chosen input and an 8-bit vector one clock later.

Top module: `rotprio_intc`

## Requirements
- R1: After reset, the pending, in-service, mask, trigger-mode and previous-level registers and the rotation offset are all zero. `intReq`, `selInput` and `vectorOut` are 0.
- R2: An input whose `trigData` bit was loaded as 1 (level mode) has a pending bit equal to its input as sampled on the previous clock. An acknowledge does not clear that pending bit.
- R3: An input whose trigger bit is 0 (edge mode) becomes pending only when it is sampled high after being sampled low. A falling input leaves the pending bit as it is. An acknowledge of that input clears its pending bit.
- R4: The priority of a set of lines is the smallest p in 0..7 such that line (p + offset) mod 8 is in the set. An empty set has priority 8. With offset 0, input 0 ranks highest.
- R5: `intReq` is a register. It is 1 one clock after a state in which the best priority among pending, unmasked lines (a mask bit of 1 blocks that line) is strictly smaller than the best priority among in-service lines.
- R6: When `specialNested` and `isMaster` are both 1, in-service line 2 is left out of the in-service priority.
- R7: An acknowledge while a line is eligible does two things. It sets that line's in-service bit. On the next clock it shows the line number on `selInput`, and on `vectorOut` it shows `{vectorBase[7:3], line}`. The low three bits of `vectorBase` have no effect.
- R8: An acknowledge with no eligible line reports line 7 and vector `{vectorBase[7:3], 3'd7}`. It changes no pending or in-service bit.
- R9: With `autoEoi` set, an acknowledge leaves no in-service bit behind. With `rotateOnAutoEoi` also set, the offset becomes (line + 1) mod 8.
- R10: An end-of-interrupt pulse clears the in-service bit of best priority. With `eoiRotate` set, the offset also becomes (that line + 1) mod 8. With nothing in service, the pulse does nothing.
- R11: A rotate pulse sets the offset to (`rotArg` + 1) mod 8, which makes `rotArg` the lowest-ranked line.
- R12: When acknowledge and end-of-interrupt arrive in the same cycle, the acknowledge is applied first. The offset update with the highest precedence is the rotate command, then the rotating end-of-interrupt, then rotation on automatic end-of-interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqLines | input | 8 | Interrupt request inputs |
| maskLoad | input | 1 | Load strobe for the mask register |
| maskData | input | 8 | New mask value, 1 blocks a line |
| trigLoad | input | 1 | Load strobe for the trigger-mode register |
| trigData | input | 8 | New trigger modes, 1 = level, 0 = edge |
| ackPulse | input | 1 | Acknowledge pulse |
| eoiPulse | input | 1 | End-of-interrupt pulse (non-specific) |
| eoiRotate | input | 1 | With eoiPulse, rotate to the cleared line |
| rotSetPulse | input | 1 | Rotate command pulse |
| rotArg | input | 3 | Line made lowest priority by the rotate command |
| autoEoi | input | 1 | Automatic end-of-interrupt mode |
| rotateOnAutoEoi | input | 1 | Rotate on automatic end-of-interrupt |
| specialNested | input | 1 | Ignore in-service line 2 on a master |
| isMaster | input | 1 | This core is the master of a cascade |
| vectorBase | input | 8 | Vector base, upper five bits used |
| intReq | output | 1 | Registered interrupt request |
| selInput | output | 3 | Line chosen by the last acknowledge |
| vectorOut | output | 8 | Vector of the last acknowledge |

## Verification
The embedded assertions check the latching rules on every cycle. An edge-mode pending bit may only rise after a high input sample. A level-mode pending bit always equals the last sampled input. The request output never rises without an unmasked pending line. An acknowledge in automatic end-of-interrupt mode leaves the in-service register unchanged. Only the bench scenarios show the remaining behaviours:

- the rotation arithmetic that picks a winner under different offsets
- the nested in-service comparison and the exemption of line 2
- the spurious vector
- the order in which an acknowledge and an end-of-interrupt arriving together are applied

// File: rtl/rotprio_pkg.sv
package rotprio_pkg;
  localparam int N_IN = 8;
  localparam int IDX_W = $clog2(N_IN);
  localparam int PRI_W = IDX_W + 1;
  localparam int VEC_W = 8;
  localparam int CASCADE_LINE = 2;

  typedef logic [N_IN-1:0] lineVec_t;
  typedef logic [IDX_W-1:0] idx_t;
  typedef logic [PRI_W-1:0] pri_t;

  localparam idx_t SPURIOUS_IDX = idx_t'(N_IN - 1);
  localparam pri_t PRI_NONE = pri_t'(N_IN);

  typedef struct packed {
    lineVec_t setIsr;
    lineVec_t clrIsr;
    lineVec_t clrIrr;
    logic     loadOff;
    idx_t     newOff;
    logic     capSel;
    idx_t     capIdx;
  } strobe_t;

  // modular-offset search: smallest p with line (p+off) mod N set
  function automatic pri_t findPri(lineVec_t m, idx_t off);
    pri_t r;
    r = PRI_NONE;
    for (int p = N_IN - 1; p >= 0; p--) begin
      if (m[(p + int'(off)) % N_IN]) r = pri_t'(p);
    end
    return r;
  endfunction

  function automatic idx_t priToIdx(pri_t p, idx_t off);
    return idx_t'((int'(p) + int'(off)) % N_IN);
  endfunction

  function automatic idx_t nextIdx(idx_t i);
    return idx_t'((int'(i) + 1) % N_IN);
  endfunction
endpackage

// File: rtl/rotprio_ctrl.sv
module rotprio_ctrl
  import rotprio_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  lineVec_t irr,
  input  lineVec_t isr,
  input  lineVec_t imr,
  input  lineVec_t trig,
  input  idx_t     offset,
  input  logic     ackPulse,
  input  logic     eoiPulse,
  input  logic     eoiRotate,
  input  logic     rotSetPulse,
  input  idx_t     rotArg,
  input  logic     autoEoi,
  input  logic     rotateOnAutoEoi,
  input  logic     specialNested,
  input  logic     isMaster,
  output strobe_t  stb,
  output logic     wantReq
);
  pri_t     pendPri, servPri, eoiPri;
  lineVec_t servMask, isrMid, winBit;
  idx_t     winIdx, offMid, eoiIdx;
  logic     eligible;

  always_comb begin
    pendPri  = findPri(irr & ~imr, offset);
    servMask = isr;
    if (specialNested && isMaster) servMask[CASCADE_LINE] = 1'b0;
    servPri  = findPri(servMask, offset);
    eligible = (pendPri < servPri);
    winIdx   = priToIdx(pendPri, offset);
    winBit   = lineVec_t'(1) << winIdx;

    stb = '0;
    // acknowledge stage, applied first
    if (ackPulse) begin
      stb.capSel = 1'b1;
      if (eligible) begin
        stb.capIdx = winIdx;
        stb.setIsr = winBit;
        stb.clrIrr = winBit & ~trig;
        if (autoEoi) begin
          stb.clrIsr = winBit;
          if (rotateOnAutoEoi) begin
            stb.loadOff = 1'b1;
            stb.newOff  = nextIdx(winIdx);
          end
        end
      end else begin
        stb.capIdx = SPURIOUS_IDX;
      end
    end

    // end-of-interrupt stage sees the post-acknowledge state
    isrMid = (isr | stb.setIsr) & ~stb.clrIsr;
    offMid = stb.loadOff ? stb.newOff : offset;
    eoiPri = findPri(isrMid, offMid);
    eoiIdx = priToIdx(eoiPri, offMid);
    if (eoiPulse && (eoiPri != PRI_NONE)) begin
      stb.clrIsr = stb.clrIsr | (lineVec_t'(1) << eoiIdx);
      if (eoiRotate) begin
        stb.loadOff = 1'b1;
        stb.newOff  = nextIdx(eoiIdx);
      end
    end

    // rotate command has the last word on the offset
    if (rotSetPulse) begin
      stb.loadOff = 1'b1;
      stb.newOff  = nextIdx(rotArg);
    end

    wantReq = eligible;
  end

  // R7
  onehot_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(stb.setIsr));

  // R9
  auto_eoi_clean_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ackPulse && autoEoi && !eoiPulse) |=> (isr == $past(isr)));
endmodule

// File: rtl/rotprio_dp.sv
module rotprio_dp
  import rotprio_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  lineVec_t          reqLines,
  input  logic              maskLoad,
  input  lineVec_t          maskData,
  input  logic              trigLoad,
  input  lineVec_t          trigData,
  input  logic [VEC_W-1:0]  vectorBase,
  input  strobe_t           stb,
  input  logic              wantReq,
  output lineVec_t          irr,
  output lineVec_t          isr,
  output lineVec_t          imr,
  output lineVec_t          trig,
  output idx_t              offset,
  output logic              intReq,
  output idx_t              selInput,
  output logic [VEC_W-1:0]  vectorOut
);
  lineVec_t prevLvl, irrNext;

  for (genvar gi = 0; gi < N_IN; gi++) begin : g_line
    always_comb begin
      if (trig[gi]) irrNext[gi] = reqLines[gi];
      else irrNext[gi] = (irr[gi] & ~stb.clrIrr[gi]) | (reqLines[gi] & ~prevLvl[gi]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      irr       <= '0;
      isr       <= '0;
      imr       <= '0;
      trig      <= '0;
      prevLvl   <= '0;
      offset    <= '0;
      intReq    <= 1'b0;
      selInput  <= '0;
      vectorOut <= '0;
    end else begin
      irr     <= irrNext;
      prevLvl <= reqLines;
      isr     <= (isr | stb.setIsr) & ~stb.clrIsr;
      if (maskLoad) imr <= maskData;
      if (trigLoad) trig <= trigData;
      if (stb.loadOff) offset <= stb.newOff;
      intReq <= wantReq;
      if (stb.capSel) begin
        selInput  <= stb.capIdx;
        vectorOut <= {vectorBase[VEC_W-1:IDX_W], stb.capIdx};
      end
    end
  end

  // R3
  edge_rise_only_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((irr & ~$past(irr) & ~$past(trig) & ~$past(reqLines)) == '0));

  // R2
  level_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    (((irr ^ $past(reqLines)) & $past(trig)) == '0));

  // R5
  req_has_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    intReq |-> $past(|(irr & ~imr)));
endmodule

// File: rtl/rotprio_intc.sv
module rotprio_intc
  import rotprio_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [7:0] reqLines,
  input  logic       maskLoad,
  input  logic [7:0] maskData,
  input  logic       trigLoad,
  input  logic [7:0] trigData,
  input  logic       ackPulse,
  input  logic       eoiPulse,
  input  logic       eoiRotate,
  input  logic       rotSetPulse,
  input  logic [2:0] rotArg,
  input  logic       autoEoi,
  input  logic       rotateOnAutoEoi,
  input  logic       specialNested,
  input  logic       isMaster,
  input  logic [7:0] vectorBase,
  output logic       intReq,
  output logic [2:0] selInput,
  output logic [7:0] vectorOut
);
  strobe_t  stb;
  logic     wantReq;
  lineVec_t irr, isr, imr, trig;
  idx_t     offset;

  rotprio_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .irr(irr), .isr(isr), .imr(imr), .trig(trig),
    .offset(offset), .ackPulse(ackPulse), .eoiPulse(eoiPulse),
    .eoiRotate(eoiRotate), .rotSetPulse(rotSetPulse), .rotArg(rotArg),
    .autoEoi(autoEoi), .rotateOnAutoEoi(rotateOnAutoEoi),
    .specialNested(specialNested), .isMaster(isMaster),
    .stb(stb), .wantReq(wantReq)
  );

  rotprio_dp u_dp (
    .clk(clk), .rstN(rstN), .reqLines(reqLines), .maskLoad(maskLoad),
    .maskData(maskData), .trigLoad(trigLoad), .trigData(trigData),
    .vectorBase(vectorBase), .stb(stb), .wantReq(wantReq),
    .irr(irr), .isr(isr), .imr(imr), .trig(trig), .offset(offset),
    .intReq(intReq), .selInput(selInput), .vectorOut(vectorOut)
  );
endmodule

// File: tb/sim_rotprio_intc.sv
`timescale 1ns/1ps
module sim_rotprio_intc;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [7:0] reqLines = '0, maskData = '0, trigData = '0, vectorBase = 8'h40;
  logic maskLoad = 0, trigLoad = 0, ackPulse = 0, eoiPulse = 0, eoiRotate = 0;
  logic rotSetPulse = 0, autoEoi = 0, rotateOnAutoEoi = 0, specialNested = 0, isMaster = 0;
  logic [2:0] rotArg = '0;
  logic intReq;
  logic [2:0] selInput;
  logic [7:0] vectorOut;
  int nChecks = 0, nFail = 0;

  always #2.5 clk = ~clk;

  rotprio_intc u0 (
    .clk(clk), .rstN(rstN), .reqLines(reqLines), .maskLoad(maskLoad),
    .maskData(maskData), .trigLoad(trigLoad), .trigData(trigData),
    .ackPulse(ackPulse), .eoiPulse(eoiPulse), .eoiRotate(eoiRotate),
    .rotSetPulse(rotSetPulse), .rotArg(rotArg), .autoEoi(autoEoi),
    .rotateOnAutoEoi(rotateOnAutoEoi), .specialNested(specialNested),
    .isMaster(isMaster), .vectorBase(vectorBase), .intReq(intReq),
    .selInput(selInput), .vectorOut(vectorOut)
  );

  // {tag[3:0], req[7:0], ack, eoi, expReq, expSel[2:0]}
  localparam int NV = 12;
  localparam logic [17:0] TBL [NV] = '{
    {4'd5,  8'h00, 1'b0, 1'b0, 1'b0, 3'd0}, // R5 idle
    {4'd3,  8'h20, 1'b0, 1'b0, 1'b1, 3'd0}, // R3 rising line 5
    {4'd7,  8'h20, 1'b1, 1'b0, 1'b0, 3'd5}, // R7 ack line 5
    {4'd4,  8'h28, 1'b0, 1'b0, 1'b1, 3'd0}, // R4 line 3 outranks 5
    {4'd7,  8'h28, 1'b1, 1'b0, 1'b0, 3'd3}, // R7 nested ack
    {4'd4,  8'h29, 1'b0, 1'b0, 1'b1, 3'd0}, // R4 line 0 outranks 3
    {4'd10, 8'h29, 1'b0, 1'b1, 1'b1, 3'd0}, // R10 eoi clears 3
    {4'd7,  8'h29, 1'b1, 1'b0, 1'b0, 3'd0}, // R7 ack line 0
    {4'd10, 8'h29, 1'b0, 1'b1, 1'b0, 3'd0}, // R10 eoi clears 0
    {4'd10, 8'h29, 1'b0, 1'b1, 1'b0, 3'd0}, // R10 eoi clears 5
    {4'd3,  8'h00, 1'b0, 1'b0, 1'b0, 3'd0}, // R3 falling ignored
    {4'd8,  8'h00, 1'b1, 1'b0, 1'b0, 3'd7}  // R8 spurious
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic step(input logic [7:0] r, input logic a, input logic e, input logic er);
    @(negedge clk);
    reqLines = r; ackPulse = a; eoiPulse = e; eoiRotate = er;
    @(negedge clk);
    ackPulse = 0; eoiPulse = 0; eoiRotate = 0;
    @(negedge clk);
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 0; reqLines = '0;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
  endtask

  task automatic loadMask(input logic [7:0] m);
    @(negedge clk); maskLoad = 1; maskData = m;
    @(negedge clk); maskLoad = 0;
    @(negedge clk);
  endtask

  task automatic loadTrig(input logic [7:0] t);
    @(negedge clk); trigLoad = 1; trigData = t;
    @(negedge clk); trigLoad = 0;
    @(negedge clk);
  endtask

  task automatic rotCmd(input logic [2:0] a);
    @(negedge clk); rotSetPulse = 1; rotArg = a;
    @(negedge clk); rotSetPulse = 0;
    @(negedge clk);
  endtask

  initial begin
    #(5.0 * 100000);
    nFail++;
    $display("FAIL R1 watchdog act=timeout exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
    $finish;
  end

  initial begin
    doReset();
    // R1 reset state
    chk("R1 intReq", {7'd0, intReq}, 8'h00);
    chk("R1 selInput", {5'd0, selInput}, 8'h00);
    chk("R1 vectorOut", vectorOut, 8'h00);

    for (int i = 0; i < NV; i++) begin
      logic [17:0] v;
      v = TBL[i];
      step(v[13:6], v[5], v[4], 1'b0);
      chk($sformatf("R%0d row%0d intReq", v[17:14], i), {7'd0, intReq}, {7'd0, v[3]});
      if (v[5]) begin
        chk($sformatf("R%0d row%0d sel", v[17:14], i), {5'd0, selInput}, {5'd0, v[2:0]});
        chk($sformatf("R%0d row%0d vec", v[17:14], i), vectorOut, {5'b01000, v[2:0]});
      end
    end

    // R2 level mode keeps request after ack
    doReset();
    loadTrig(8'h02);
    step(8'h02, 0, 0, 0);
    chk("R2 level pending", {7'd0, intReq}, 8'h01);
    step(8'h02, 1, 0, 0);
    chk("R2 ack sel", {5'd0, selInput}, 8'h01);
    chk("R2 blocked by own isr", {7'd0, intReq}, 8'h00);
    step(8'h02, 0, 1, 0);
    chk("R2 still pending after eoi", {7'd0, intReq}, 8'h01);
    step(8'h00, 0, 0, 0);
    chk("R2 follows low input", {7'd0, intReq}, 8'h00);

    // R5 masking
    doReset();
    loadMask(8'h10);
    step(8'h10, 0, 0, 0);
    chk("R5 masked line silent", {7'd0, intReq}, 8'h00);
    loadMask(8'h00);
    chk("R5 unmask releases", {7'd0, intReq}, 8'h01);

    // R11 rotate command, R4 ranking, R10 rotating eoi
    doReset();
    rotCmd(3'd3);
    step(8'h42, 0, 0, 0);
    step(8'h42, 1, 0, 0);
    chk("R11 offset 4 picks line 6", {5'd0, selInput}, 8'h06);
    chk("R4 line 1 ranks below 6", {7'd0, intReq}, 8'h00);
    step(8'h42, 0, 1, 1);
    chk("R10 rotating eoi frees line 1", {7'd0, intReq}, 8'h01);
    step(8'h42, 1, 0, 0);
    chk("R10 ack after rotation", {5'd0, selInput}, 8'h01);

    // R9 automatic eoi with rotation
    doReset();
    autoEoi = 1; rotateOnAutoEoi = 1;
    step(8'h14, 0, 0, 0);
    step(8'h14, 1, 0, 0);
    chk("R9 first ack line 2", {5'd0, selInput}, 8'h02);
    chk("R9 no isr left, line 4 requests", {7'd0, intReq}, 8'h01);
    step(8'h14, 1, 0, 0);
    chk("R9 second ack line 4", {5'd0, selInput}, 8'h04);
    step(8'h00, 0, 0, 0);
    step(8'h24, 0, 0, 0);
    step(8'h24, 1, 0, 0);
    chk("R9 offset 5 picks line 5", {5'd0, selInput}, 8'h05);
    autoEoi = 0; rotateOnAutoEoi = 0;

    // R6 special nested on master
    doReset();
    isMaster = 1; specialNested = 1;
    step(8'h04, 0, 0, 0);
    step(8'h04, 1, 0, 0);
    step(8'h00, 0, 0, 0);
    step(8'h04, 0, 0, 0);
    chk("R6 line 2 re-requests", {7'd0, intReq}, 8'h01);
    specialNested = 0;
    @(negedge clk);
    chk("R6 nested off blocks line 2", {7'd0, intReq}, 8'h00);
    isMaster = 0;

    // R12 ack and eoi together, R7 low base bits ignored
    doReset();
    vectorBase = 8'h97;
    step(8'h08, 0, 0, 0);
    step(8'h08, 1, 1, 0);
    chk("R12 ack sel", {5'd0, selInput}, 8'h03);
    chk("R7 vector base low bits", vectorOut, 8'h93);
    step(8'h28, 0, 0, 0);
    chk("R12 isr cleared by same-cycle eoi", {7'd0, intReq}, 8'h01);

    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
    $finish;
  end
endmodule